// File: doc/BRIEF.md
# Hex Record Payload Extractor

This block accepts a configuration image written as ASCII hex records, one character per valid/ready beat. It keeps only the payload of each record and delivers those bytes downstream in binary, one byte per valid/ready beat. A colon marks the start of a record. The two characters after the colon give the payload byte count. Six further characters carry a load address and a record kind, and the block reads them and discards them. The payload characters follow. The checksum and any line breaks after the payload are never decoded: the parser simply passes over them while it looks for the next colon.

A configuration loader places the block between a character source and a byte sink. When the sink stalls, the block pushes back on the character source, so no character is lost. The source marks the final character of an image. After that beat the parser returns to its starting state and gives the next stage a one-cycle completion pulse.

Top module: `hexrec_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid and doneStrobe are 0 and inReady is 1, provided outReady is 1.
- R2: The first character accepted after reset, or after a final-character beat, is discarded whatever its value, including a colon (8'h3A).
- R3: While the parser is searching, every character other than the colon (8'h3A) is consumed and produces no output byte.
- R4: A count field of 00 produces no output. The parser goes back to searching, so the characters that follow are ignored until the next colon.
- R5: The three bytes (six characters) that follow the count are consumed and never appear on outByte.
- R6: Every record delivers exactly as many payload bytes as its count, in stream order. After the last payload byte, the parser searches for a colon again.
- R7: Each byte is built from two characters, with the first giving bits 7:4. The characters '0'-'9' map to 0-9, and both 'A'-'F' and 'a'-'f' map to 10-15.
- R8: While outValid is 1 and outReady is 0, outValid stays 1, outByte holds its value, and inReady is 0.
- R9: Accepting a character with inLast set causes one doneStrobe pulse in the following cycle and returns the parser to its starting state (see R2).
- R10: A payload byte becomes valid on outByte in the cycle after its second character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Character source has a character |
| inChar | input | 8 | ASCII character |
| inLast | input | 1 | This character is the last of the image |
| inReady | output | 1 | Parser accepts a character this cycle |
| outValid | output | 1 | Payload byte available |
| outByte | output | 8 | Payload byte in binary |
| outReady | input | 1 | Byte sink accepts the byte |
| doneStrobe | output | 1 | One-cycle pulse after the last character |

## Verification
If the parser's phase or state is wrong, the output byte stream goes wrong within one record. A missed or extra nibble phase swaps nibbles or shifts every later byte. A wrong header or payload count either leaks header or checksum bytes as data or drops payload bytes, and the byte-by-byte comparison catches this at the first affected byte. A flush that fails to reset the state shows up in the next image, where a colon sent as its first character would start a spurious record.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_DROP,
    ST_HUNT,
    ST_COUNT,
    ST_HEADER,
    ST_DATA
  } parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchHi;
    logic emit;
  } dpCtrl_t;

  // ASCII hex digit to nibble; lower case folded first
  function automatic logic [NIB_W-1:0] hexNibble(input logic [CHAR_W-1:0] c);
    logic [CHAR_W-1:0] u;
    logic [CHAR_W-1:0] v;
    u = (c >= 8'h61 && c <= 8'h7A) ? c - 8'd32 : c;
    v = u - 8'h30;
    if (v > 8'd9) v = v - 8'd7;
    return v[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/hexrec_datapath.sv
module hexrec_datapath
  import hexrec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] inChar,
  input  dpCtrl_t           ctrl,
  input  logic              outReady,
  output logic [BYTE_W-1:0] assembled,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte
);
  logic [NIB_W-1:0] hiNib;

  assign assembled = {hiNib, hexNibble(inChar)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib    <= '0;
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      if (ctrl.latchHi) hiNib <= hexNibble(inChar);
      if (ctrl.emit) begin
        outValid <= 1'b1;
        outByte  <= assembled;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hexrec_control.sv
module hexrec_control
  import hexrec_pkg::*;
#(
  parameter int              HDR_BYTES  = 3,
  parameter logic [CHAR_W-1:0] START_CHAR = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] inChar,
  input  logic              inLast,
  input  logic              outValid,
  input  logic              outReady,
  input  logic [BYTE_W-1:0] assembled,
  output logic              inReady,
  output dpCtrl_t           ctrl,
  output logic              doneStrobe
);
  localparam int IDX_W = $clog2(HDR_BYTES + 1);

  parseState_t       state;
  logic              loPhase;
  logic [IDX_W-1:0]  hdrIdx;
  logic [BYTE_W-1:0] remaining;
  logic              accept;

  always_comb begin
    inReady      = !(outValid && !outReady);
    accept       = inValid && inReady;
    ctrl.latchHi = accept && !loPhase &&
                   (state == ST_COUNT || state == ST_HEADER || state == ST_DATA);
    ctrl.emit    = accept && loPhase && (state == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_DROP;
      loPhase    <= 1'b0;
      hdrIdx     <= '0;
      remaining  <= '0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= accept && inLast;
      if (accept) begin
        if (inLast) begin
          state   <= ST_DROP;
          loPhase <= 1'b0;
        end else begin
          case (state)
            ST_DROP: state <= ST_HUNT;
            ST_HUNT: begin
              if (inChar == START_CHAR) begin
                state   <= ST_COUNT;
                loPhase <= 1'b0;
              end
            end
            ST_COUNT: begin
              if (!loPhase) loPhase <= 1'b1;
              else begin
                loPhase   <= 1'b0;
                remaining <= assembled;
                hdrIdx    <= '0;
                state     <= (assembled == '0) ? ST_HUNT : ST_HEADER;
              end
            end
            ST_HEADER: begin
              if (!loPhase) loPhase <= 1'b1;
              else begin
                loPhase <= 1'b0;
                if (hdrIdx == IDX_W'(HDR_BYTES - 1)) state <= ST_DATA;
                else hdrIdx <= hdrIdx + 1'b1;
              end
            end
            ST_DATA: begin
              if (!loPhase) loPhase <= 1'b1;
              else begin
                loPhase   <= 1'b0;
                remaining <= remaining - 1'b1;
                if (remaining == BYTE_W'(1)) state <= ST_HUNT;
              end
            end
            default: state <= ST_DROP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int                HDR_BYTES  = 3,
  parameter logic [CHAR_W-1:0] START_CHAR = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] inChar,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  input  logic              outReady,
  output logic              doneStrobe
);
  dpCtrl_t           ctrl;
  logic [BYTE_W-1:0] assembled;

  hexrec_control #(.HDR_BYTES(HDR_BYTES), .START_CHAR(START_CHAR)) ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar),
    .inLast(inLast), .outValid(outValid), .outReady(outReady),
    .assembled(assembled), .inReady(inReady), .ctrl(ctrl),
    .doneStrobe(doneStrobe)
  );

  hexrec_datapath dp (
    .clk(clk), .rstN(rstN), .inChar(inChar), .ctrl(ctrl),
    .outReady(outReady), .assembled(assembled), .outValid(outValid),
    .outByte(outByte)
  );
endmodule

// File: rtl/hexrec_checker.sv
module hexrec_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inChar,
  input logic       inLast,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outByte,
  input logic       outReady,
  input logic       doneStrobe
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> $past(inValid && inReady && inLast));

  // R10
  emit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));
endmodule

bind hexrec_parser hexrec_checker chk (.*);

// File: tb/hexrec_parser_test.sv
`timescale 1ns/1ps
module hexrec_parser_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inChar;
  logic       inLast;
  logic       inReady;
  logic       outValid;
  logic [7:0] outByte;
  logic       outReady;
  logic       doneStrobe;

  always #2.5 clk = ~clk;

  hexrec_parser uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar),
    .inLast(inLast), .inReady(inReady), .outValid(outValid),
    .outByte(outByte), .outReady(outReady), .doneStrobe(doneStrobe)
  );

  bit [7:0] charQ[$];
  bit       lastQ[$];
  bit [7:0] expQ[$];
  int  checks = 0;
  int  fails = 0;
  int  donePulses = 0;
  bit  freeRun = 1'b1;
  bit  stalledPrev = 1'b0;
  bit [7:0] heldByte = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] hexChar(input bit [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic pushChar(input bit [7:0] c);
    charQ.push_back(c);
    lastQ.push_back(1'b0);
  endtask

  task automatic pushByte(input bit [7:0] b, input bit lower);
    pushChar(hexChar(b[7:4], lower));
    pushChar(hexChar(b[3:0], lower));
  endtask

  task automatic addRecord(input int cnt, input bit lower);
    bit [7:0] d;
    pushChar(8'h3A);
    pushByte(8'(cnt), lower);
    for (int h = 0; h < 3; h++) pushByte(8'($urandom_range(0, 255)), lower);
    for (int k = 0; k < cnt; k++) begin
      d = 8'($urandom_range(0, 255));
      pushByte(d, lower);
      expQ.push_back(d);
    end
    pushByte(8'($urandom_range(0, 255)), lower);
    pushChar(8'h0D);
    pushChar(8'h0A);
  endtask

  task automatic endStream();
    lastQ[lastQ.size()-1] = 1'b1;
  endtask

  task automatic runStream();
    while (charQ.size() > 0) begin
      if ($urandom_range(0, 3) == 0) begin
        inValid = 1'b0;
        repeat ($urandom_range(1, 3)) @(posedge clk);
        #1;
      end
      inChar  = charQ.pop_front();
      inLast  = lastQ.pop_front();
      inValid = 1'b1;
      do @(negedge clk); while (!inReady);
      @(posedge clk);
      #1;
      inValid = 1'b0;
      inLast  = 1'b0;
    end
  endtask

  task automatic drain();
    freeRun = 1'b1;
    repeat (20) @(posedge clk);
    #1;
  endtask

  // byte sink
  initial begin
    outReady = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      outReady = freeRun ? 1'b1 : ($urandom_range(0, 9) < 6);
    end
  end

  // monitor, sampled between edges
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (stalledPrev) begin
          check(outValid && outByte == heldByte, "R8 held byte", int'(outByte), int'(heldByte));
        end
        if (outValid && !outReady) begin
          check(!inReady, "R8 inReady during stall", int'(inReady), 0);
        end
        stalledPrev = outValid && !outReady;
        heldByte    = outByte;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R6 unexpected byte (R2 R3 R4 R9)", int'(outByte), 0);
          end else begin
            bit [7:0] e;
            e = expQ.pop_front();
            check(outByte == e, "R5 R6 R7 payload byte", int'(outByte), int'(e));
          end
        end
        if (doneStrobe) donePulses++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; inChar = 8'h00; inLast = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    check(!outValid, "R1 outValid in reset", int'(outValid), 0);
    check(!doneStrobe, "R1 doneStrobe in reset", int'(doneStrobe), 0);
    check(inReady, "R1 inReady in reset", int'(inReady), 1);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !doneStrobe, "R1 after release", int'(outValid), 0);
    @(posedge clk); #1;

    // image A: directed corners (R2 R3 R4 R7 R10)
    pushChar(8'h3A); pushChar(8'h46); pushChar(8'h46);
    pushChar(8'h7A); pushChar(8'h0A); pushChar(8'h31);
    addRecord(2, 1'b0);
    addRecord(0, 1'b0);
    pushChar(8'h32); pushChar(8'h33);
    addRecord(4, 1'b1);
    addRecord(1, 1'b0);
    endStream();
    freeRun = 1'b1;
    runStream();
    drain();
    check(expQ.size() == 0, "R6 image A fully delivered", expQ.size(), 0);
    check(donePulses == 1, "R9 done pulse image A", donePulses, 1);

    // R10 single byte latency
    pushChar(8'h0A); pushChar(8'h3A); pushChar(8'h30); pushChar(8'h31);
    for (int h = 0; h < 6; h++) pushChar(8'h30);
    pushChar(8'h61); pushChar(8'h35);
    expQ.push_back(8'hA5);
    while (charQ.size() > 1) begin
      inChar = charQ.pop_front(); void'(lastQ.pop_front()); inValid = 1'b1;
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
    end
    inChar = charQ.pop_front(); void'(lastQ.pop_front()); inLast = 1'b1;
    @(negedge clk);
    check(!outValid, "R10 not valid before second char", int'(outValid), 0);
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
    @(negedge clk);
    check(outValid && outByte == 8'hA5, "R10 R7 byte next cycle", int'(outByte), 'hA5);
    check(doneStrobe, "R9 strobe after last", int'(doneStrobe), 1);
    @(posedge clk); #1;
    @(negedge clk);
    check(!doneStrobe, "R9 single pulse", int'(doneStrobe), 0);
    drain();

    // image B: colon as first char must be dropped, then random records
    pushChar(8'h3A);
    pushChar(8'h30); pushChar(8'h33);
    for (int h = 0; h < 6; h++) pushChar(8'h30);
    pushChar(8'h31); pushChar(8'h31); pushChar(8'h32); pushChar(8'h32);
    for (int r = 0; r < 30; r++) addRecord($urandom_range(0, 16), $urandom_range(0, 1) == 1);
    endStream();
    freeRun = 1'b0;
    runStream();
    drain();
    check(expQ.size() == 0, "R6 image B fully delivered", expQ.size(), 0);
    check(donePulses == 3, "R9 done pulse count", donePulses, 3);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule